// File: doc/BRIEF.md
# Quasi-Cyclic Systematic IRA Encoder

This block turns one block of K information bits into a systematic irregular repeat-accumulate codeword of K + M bits, where M = L·Q. The information part of the code is described by an L×J grid of Q×Q square blocks. Each block is either all zero or a Q×Q identity matrix rotated right by a per-block exponent. A small exponent table inside the block holds one code per grid cell. It is written through a configuration port while the encoder is idle.

Information bits arrive one per cycle under a valid strobe. The first bit of a block carries a start flag. Each accepted bit is passed straight to the output, so the systematic part leaves unchanged. When the last information bit has been taken, the encoder produces M parity bits back to back. For each parity position it picks one row of the circulant grid in a fixed row-column interleaved order. It forms the XOR of the information bits that row selects and folds that sum into a running 1/(1⊕D) accumulator. Columns beyond K, which are the deleted right-most columns of the grid, contribute nothing. The final parity bit is flagged as last.

Top module: `qcira_encoder`

## Requirements
- R1: After reset, out_valid, out_last and busy are 0, and every exponent table entry holds the masked code, so a block encoded straight after reset has all-zero parity.
- R2: Each accepted information bit appears unchanged on out_bit with out_valid high one cycle after it is accepted. The K systematic bits come in the order they arrived. A block starts only with in_valid and in_start both high while idle.
- R3: Exactly M parity bits follow the K systematic bits, with no gap. out_last is high only with the final parity bit, for a total of K + M valid outputs per block.
- R4: Circulant row r of block-row l includes, for each column group j whose entry e is unmasked, information bit j·Q + ((r + e) mod Q). Indices of K or above contribute 0.
- R5: Any exponent code of Q or above (8 or above with defaults, on the 4-bit cfg_exp) masks the block, which then contributes nothing.
- R6: Parity bit i, counted from 0, uses circulant-grid row (i mod L)·Q + (i div L).
- R7: The accumulator is cleared at every block start. Parity bit i equals parity bit i−1 XOR the check sum for position i, and parity bit 0 equals its own check sum.
- R8: Each emitted codeword satisfies H·c = 0, where check row i is the row of R6 over the information bits, XOR parity i, XOR parity i−1 for i > 0.
- R9: Configuration writes while busy is high leave the table unchanged, both for the current block and for later blocks.
- R10: While idle, in_valid without in_start starts nothing. Input strobes during the parity phase are ignored.
- R11: Cycles without in_valid during the systematic phase pause the block without losing or repeating bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Exponent table write strobe |
| cfg_row | input | 2 | Block-row index of the table entry |
| cfg_col | input | 2 | Column-group index of the table entry |
| cfg_exp | input | 4 | Exponent code; Q or above masks the block |
| in_valid | input | 1 | Information bit valid |
| in_start | input | 1 | First bit of a block |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Codeword bit valid |
| out_bit | output | 1 | Codeword bit |
| out_last | output | 1 | Final parity bit of the block |
| busy | output | 1 | Block in progress |

## Verification
A single information bit placed against a single unmasked block lights exactly one check row. This pins down the rotation direction and the interleaved position, and the step it leaves in the accumulated parity shows the running XOR. All-ones data against a block in the last, partly deleted column group separates deleted positions from real ones. A mixed table with several exponents and masked cells, driven with paused input, is compared with a full expanded-matrix product and with a parity-check test of the received word. Out-of-range exponent codes, writes during a block and stray strobes are each followed by encodes that would change if those inputs had any effect.

// File: rtl/qcira_pkg.sv
package qcira_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYS  = 2'd1,
    ST_PAR  = 2'd2
  } enc_state_e;

  // Column offset inside a block for circulant row r rotated right by e.
  function automatic int unsigned circ_tap(int unsigned r, int unsigned e, int unsigned q);
    return (r + e) % q;
  endfunction

  // Circulant-grid row consumed by parity position idx.
  function automatic int unsigned ilv_row(int unsigned idx, int unsigned nl, int unsigned nq);
    return (idx % nl) * nq + idx / nl;
  endfunction

endpackage

// File: rtl/qcira_exp_table.sv
module qcira_exp_table #(
  parameter int L  = 4,
  parameter int J  = 4,
  parameter int EW = 4,
  localparam int LW = (L > 1) ? $clog2(L) : 1,
  localparam int JW = (J > 1) ? $clog2(J) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_row,
  input  logic [JW-1:0]     wr_col,
  input  logic [EW-1:0]     wr_exp,
  input  logic              lock,
  output logic [L*J*EW-1:0] tbl_flat
);

  logic wr_ok;
  assign wr_ok = wr_en && !lock;

  for (genvar gl = 0; gl < L; gl++) begin : g_row
    for (genvar gj = 0; gj < J; gj++) begin : g_col
      logic [EW-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= '1;
        end else if (wr_ok && (int'(wr_row) == gl) && (int'(wr_col) == gj)) begin
          ent_q <= wr_exp;
        end
      end
      assign tbl_flat[(gl*J+gj)*EW +: EW] = ent_q;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en) |=> $stable(tbl_flat)); // R9

endmodule

// File: rtl/qcira_info_buf.sv
module qcira_info_buf #(
  parameter int K = 30,
  localparam int CW = $clog2(K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic          wr_bit,
  output logic [K-1:0]  info
);

  for (genvar gi = 0; gi < K; gi++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        info[gi] <= 1'b0;
      end else if (wr_en && (int'(wr_idx) == gi)) begin
        info[gi] <= wr_bit;
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < K)); // R2

endmodule

// File: rtl/qcira_parity_gen.sv
module qcira_parity_gen #(
  parameter int L  = 4,
  parameter int J  = 4,
  parameter int Q  = 8,
  parameter int K  = 30,
  parameter int EW = 4,
  localparam int LW = (L > 1) ? $clog2(L) : 1,
  localparam int QW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [LW-1:0]     row_l,
  input  logic [QW-1:0]     row_q,
  input  logic [L*J*EW-1:0] tbl_flat,
  input  logic [K-1:0]      info,
  output logic              sum_bit,
  output logic              par_bit,
  output logic              acc_q
);

  import qcira_pkg::*;

  always_comb begin
    sum_bit = 1'b0;
    for (int j = 0; j < J; j++) begin
      logic [EW-1:0] e;
      int unsigned   col;
      e   = tbl_flat[(int'(row_l)*J + j)*EW +: EW];
      col = 32'(j*Q) + circ_tap(32'(row_q), 32'(e), 32'(Q));
      if ((int'(e) < Q) && (col < 32'(K))) begin
        sum_bit = sum_bit ^ info[col];
      end
    end
  end

  assign par_bit = acc_q ^ sum_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
    end else if (clr) begin
      acc_q <= 1'b0;
    end else if (step) begin
      acc_q <= par_bit;
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == 1'b0)); // R7

endmodule

// File: rtl/qcira_encoder.sv
module qcira_encoder #(
  parameter int L  = 4,
  parameter int J  = 4,
  parameter int Q  = 8,
  parameter int K  = 30,
  parameter int EW = $clog2(Q) + 1,
  localparam int M  = L * Q,
  localparam int LW = (L > 1) ? $clog2(L) : 1,
  localparam int JW = (J > 1) ? $clog2(J) : 1,
  localparam int QW = (Q > 1) ? $clog2(Q) : 1,
  localparam int CW = $clog2(K + 1),
  localparam int IW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_row,
  input  logic [JW-1:0] cfg_col,
  input  logic [EW-1:0] cfg_exp,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_bit,
  output logic          out_valid,
  output logic          out_bit,
  output logic          out_last,
  output logic          busy
);

  import qcira_pkg::*;

  enc_state_e        state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     pidx;
  logic [LW-1:0]     pl;
  logic [QW-1:0]     pq;
  logic [L*J*EW-1:0] tbl_flat;
  logic [K-1:0]      info;
  logic              sum_bit, par_bit, acc_q;

  // Named internal events
  logic          start_evt, take_bit, last_sys, par_step, last_par;
  logic [CW-1:0] wr_idx;

  assign start_evt = (state == ST_IDLE) && in_valid && in_start;
  assign take_bit  = start_evt || ((state == ST_SYS) && in_valid);
  assign wr_idx    = start_evt ? '0 : cnt;
  assign last_sys  = take_bit && (wr_idx == CW'(K-1));
  assign par_step  = (state == ST_PAR);
  assign last_par  = par_step && (pidx == IW'(M-1));
  assign busy      = (state != ST_IDLE);

  qcira_exp_table #(.L(L), .J(J), .EW(EW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_row(cfg_row),
    .wr_col(cfg_col), .wr_exp(cfg_exp), .lock(busy), .tbl_flat(tbl_flat)
  );

  qcira_info_buf #(.K(K)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(take_bit), .wr_idx(wr_idx),
    .wr_bit(in_bit), .info(info)
  );

  qcira_parity_gen #(.L(L), .J(J), .Q(Q), .K(K), .EW(EW)) u_par (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .step(par_step),
    .row_l(pl), .row_q(pq), .tbl_flat(tbl_flat), .info(info),
    .sum_bit(sum_bit), .par_bit(par_bit), .acc_q(acc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pidx      <= '0;
      pl        <= '0;
      pq        <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= take_bit || par_step;
      out_bit   <= par_step ? par_bit : in_bit;
      out_last  <= last_par;
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            cnt   <= CW'(1);
            pidx  <= '0;
            pl    <= '0;
            pq    <= '0;
            state <= last_sys ? ST_PAR : ST_SYS;
          end
        end
        ST_SYS: begin
          if (take_bit) begin
            cnt <= cnt + 1'b1;
            if (last_sys) state <= ST_PAR;
          end
        end
        ST_PAR: begin
          pidx <= pidx + 1'b1;
          if (pl == LW'(L-1)) begin
            pl <= '0;
            pq <= pq + 1'b1;
          end else begin
            pl <= pl + 1'b1;
          end
          if (last_par) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R3
  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_last); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && out_valid)); // R2
  AST_ILV_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    par_step |-> (32'(pidx) == 32'(pq) * 32'(L) + 32'(pl))); // R6
  AST_PAR_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    par_step |-> !take_bit); // R10

endmodule

// File: tb/qcira_encoder_tb.sv
module qcira_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4, J = 4, Q = 8, K = 30, EW = 4;
  localparam int M = L * Q;
  localparam int N = K + M;
  localparam int MASK = (1 << EW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_row = 0, cfg_col = 0; logic [EW-1:0] cfg_exp = 0;
  logic in_valid = 0, in_start = 0, in_bit = 0;
  logic out_valid, out_bit, out_last, busy;

  int errors = 0, checks = 0;
  int rtbl [L][J];
  logic [M-1:0] last_par;

  always #(CLK_PERIOD/2) clk = ~clk;

  qcira_encoder #(.L(L), .J(J), .Q(Q), .K(K), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col),
    .cfg_exp(cfg_exp), .in_valid(in_valid), .in_start(in_start), .in_bit(in_bit),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expanded-matrix entry of the circulant grid, scanned by column.
  function automatic bit grid_dot(int row, logic [K-1:0] u);
    bit s = 0;
    int l = row / Q, r = row % Q;
    for (int c = 0; c < K; c++) begin
      int e = rtbl[l][c / Q];
      if (e < Q && (c % Q) == (r + e) % Q) s ^= u[c];
    end
    return s;
  endfunction

  function automatic logic [M-1:0] ref_par(logic [K-1:0] u);
    logic [M-1:0] p;
    bit a = 0;
    for (int i = 0; i < M; i++) begin
      a ^= grid_dot((i % L) * Q + i / L, u);
      p[i] = a;
    end
    return p;
  endfunction

  task automatic cfg_write(input int l, input int j, input int e);
    @(negedge clk);
    cfg_we = 1; cfg_row = 2'(l); cfg_col = 2'(j); cfg_exp = EW'(e);
    @(negedge clk);
    cfg_we = 0;
    rtbl[l][j] = e;
  endtask

  task automatic mask_all();
    for (int l = 0; l < L; l++) for (int j = 0; j < J; j++) cfg_write(l, j, MASK);
  endtask

  task automatic run_block(input logic [K-1:0] u, input bit gaps, input bit junk,
                           input int cfg_at, input string tag);
    logic [N-1:0] ob = '0;
    int n = 0, di = 0, cyc = 0, lastcnt = 0, lastat = -1, bad = 0;
    logic [M-1:0] exp_p;
    while (n < N && cyc < 2000) begin
      @(negedge clk);
      if (out_valid) begin
        ob[n] = out_bit;
        if (out_last) begin lastcnt++; lastat = n; end
        n++;
      end
      if (n >= N) break;
      if (di < K) begin
        bit gap = gaps && (cyc % 3 == 1);
        in_valid = !gap; in_start = (di == 0) && !gap;
        in_bit = gap ? ~u[di] : u[di];
        if (!gap) di++;
      end else begin
        in_valid = junk; in_start = junk; in_bit = cyc[0];
      end
      cfg_we = (cyc == cfg_at); cfg_row = 2'd1; cfg_col = 2'd1; cfg_exp = EW'(6);
      cyc++;
    end
    in_valid = 0; in_start = 0; cfg_we = 0;
    chk(n == N, "R3", n, N, {tag, " output count"});
    for (int i = 0; i < K; i++) if (ob[i] != u[i]) bad++;
    chk(bad == 0, "R2", bad, 0, {tag, " systematic mismatches"});
    exp_p = ref_par(u);
    bad = 0;
    for (int i = 0; i < M; i++) if (ob[K+i] != exp_p[i]) bad++;
    chk(bad == 0, "R7", bad, 0, {tag, " parity mismatches vs expanded matrix"});
    chk(lastcnt == 1 && lastat == N-1, "R3", lastat, N-1, {tag, " out_last position"});
    bad = 0;
    for (int i = 0; i < M; i++) begin
      bit s = grid_dot((i % L) * Q + i / L, u) ^ ob[K+i] ^ ((i > 0) ? ob[K+i-1] : 1'b0);
      if (s) bad++;
    end
    chk(bad == 0, "R8", bad, 0, {tag, " unsatisfied check rows"});
    @(negedge clk);
    chk(busy == 0, "R3", busy, 0, {tag, " busy after block"});
    last_par = ob[N-1:K];
  endtask

  function automatic logic [K-1:0] pat(int seed);
    logic [K-1:0] v;
    for (int i = 0; i < K; i++) v[i] = ((i * 7 + seed) % 5) < 2;
    return v;
  endfunction

  task automatic t_reset();
    chk(out_valid == 0 && out_last == 0 && busy == 0, "R1", busy, 0, "outputs after reset");
    run_block('1, 0, 0, -1, "reset_table");
    chk(last_par == '0, "R1", int'(last_par != 0), 0, "parity with masked table");
  endtask

  task automatic t_onehot();
    logic [K-1:0] u = '0;
    logic [M-1:0] e;
    mask_all();
    cfg_write(1, 2, 3);
    u[16] = 1'b1;            // row q=5 of block-row 1 taps column 2*8+(5+3)%8
    run_block(u, 0, 0, -1, "onehot");
    for (int i = 0; i < M; i++) e[i] = (i >= 5 * L + 1);
    chk(last_par == e, "R6", int'(last_par[21]), 1, "single tap lands at parity 21 and accumulates");
    chk(last_par[20:0] == '0, "R4", int'(last_par[20:0] != 0), 0, "right-shift tap selects no other row");
  endtask

  task automatic t_deleted();
    logic [M-1:0] e;
    bit a = 0;
    mask_all();
    cfg_write(0, 3, 0);
    run_block('1, 0, 0, -1, "deleted_cols");
    for (int i = 0; i < M; i++) begin
      a ^= (i % L == 0) && (i / L < 6);   // columns 30,31 do not exist
      e[i] = a;
    end
    chk(last_par == e, "R4", int'(last_par[31]), int'(e[31]), "deleted columns contribute zero");
  endtask

  task automatic t_full();
    for (int l = 0; l < L; l++)
      for (int j = 0; j < J; j++)
        cfg_write(l, j, ((l + j) % 5 == 4) ? MASK : (l * 3 + j * 5) % Q);
    run_block(pat(1), 1, 0, -1, "full_gaps_R11");
    run_block(pat(3), 0, 0, -1, "full_plain");
  endtask

  task automatic t_masked();
    cfg_write(2, 1, Q + 3);
    cfg_write(3, 0, 15);
    run_block(pat(2), 0, 0, -1, "masked_codes_R5");
    cfg_write(2, 1, 0);
    run_block(pat(2), 0, 0, -1, "unmasked_again_R5");
  endtask

  task automatic t_locked();
    mask_all();
    cfg_write(0, 0, 2);
    run_block(pat(4), 0, 0, 5, "write_while_busy_R9");
    run_block(pat(4), 0, 0, -1, "after_locked_write_R9");
  endtask

  task automatic t_stray();
    int seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (out_valid || busy) seen++;
      in_valid = 1; in_start = 0; in_bit = 1;
    end
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    if (out_valid || busy) seen++;
    chk(seen == 0, "R10", seen, 0, "valid without start while idle");
    cfg_write(1, 3, 5);
    run_block(pat(5), 0, 1, -1, "junk_in_parity_R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int l = 0; l < L; l++) for (int j = 0; j < J; j++) rtbl[l][j] = MASK;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_onehot();
    t_deleted();
    t_full();
    t_masked();
    t_locked();
    t_stray();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule